// File: doc/BRIEF.md
# Command Ring Fetch Controller

This block fetches 32-bit commands from a 256-entry ring in system memory (4 bytes per entry, 1 KB in all) and hands them to a downstream consumer through a valid/ready output. Software fills the ring and advances a write pointer. While the engine runs, it reads every entry between its own fetch position and that write pointer over a memory read request/response port. The entries land in a small prefetch buffer. The read pointer that software sees always names the last entry whose fetch completed without error, so software may overwrite that slot.

Four registers sit on a simple word-addressed register bus. Reads are combinational and writes take effect at the clock edge. Stopping the engine and resetting the read pointer are both two-phase handshakes, and their control bits read back the true hardware state. The run bit keeps reading 1 until in-flight fetches have drained. The pointer-reset bit reads 1 only after the pointer has been zeroed and the prefetch buffer emptied. A memory error response sets a sticky status bit, halts the engine and can raise an interrupt.

Top module: `cmd_ring_fetch`

## Requirements
- R1: After reset, every register reads 0 (no run, no interrupt enable, pointers at 0, no error, reset bit 0), `irq`, `cmd_valid` and `mem_req_valid` are low.
- R2: Register addresses are 0 read pointer, 1 write pointer, 2 control, 3 status. The write-pointer register holds bits 7:0 of a write. Bits 7:0 of the read-pointer register cannot be written. Control bit 1 is run and bit 0 is interrupt enable. Every unused bit reads 0.
- R3: While run is set, the engine fetches entry (last fetched + 1) at byte address 4 × index whenever that entry is not past the write pointer and the buffer has room. The read pointer advances by one per good response, and commands leave `cmd_data` in ring order.
- R4: The ring index wraps from 255 to 0 for both the fetch address and the read pointer.
- R5: Outstanding fetches plus buffered commands never exceed PF_DEPTH (4). With `cmd_ready` low, the read pointer stops 4 entries past its start.
- R6: After run is written 0, control bit 1 keeps reading 1 until no fetch is outstanding, then reads 0. When nothing is outstanding, it reads 0 in the cycle after the write.
- R7: Writing 1 to read-pointer bit 15 requests a pointer reset. The request is held off while control bit 1 reads 1. Once idle, the read pointer becomes 0, buffered commands are discarded without delivery, and bit 15 reads 1 from the next cycle on.
- R8: Writing 0 to bit 15 after an acknowledged reset makes it read 0 one cycle later.
- R9: An error response sets status bit 0, clears the run bit, leaves the read pointer unchanged and discards responses still in flight. A later run resumes fetching at read pointer + 1.
- R10: Writing 1 to status bit 0 clears it. Writing 0 leaves it unchanged.
- R11: `irq` is high exactly when status bit 0 and control bit 0 are both 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| reg_addr | input | 2 | Register word address |
| reg_we | input | 1 | Register write strobe |
| reg_wdata | input | 16 | Register write data |
| reg_rdata | output | 16 | Register read data (combinational) |
| mem_req_valid | output | 1 | Fetch request valid |
| mem_req_ready | input | 1 | Fetch request accepted |
| mem_req_addr | output | 10 | Byte offset of the entry within the ring |
| mem_rsp_valid | input | 1 | Fetch response valid (in request order) |
| mem_rsp_err | input | 1 | Fetch response carries an error |
| mem_rsp_data | input | 32 | Fetched command word |
| cmd_valid | output | 1 | Command available |
| cmd_ready | input | 1 | Consumer takes the command |
| cmd_data | output | 32 | Command word |
| irq | output | 1 | Memory-error interrupt |

## Verification
A register write is visible in the read data in the cycle that follows its edge. A pointer-reset acknowledge or release shows one cycle after that, and the bench reads at the falling edge accordingly. The bench memory answers each accepted fetch two edges later, so a fetch issued one edge after a run write moves the read pointer three edges after that write. The stop check reads the run bit in the window where that fetch is still in flight. Results that need many fetches are read only after a settle window several times longer than the fetch latency, and the delivered stream is then compared entry by entry against the ring indices expected.

// File: rtl/cmd_ring_pkg.sv
package cmd_ring_pkg;
   typedef enum logic [1:0] {
      RA_RPTR = 2'd0,
      RA_WPTR = 2'd1,
      RA_CTRL = 2'd2,
      RA_STAT = 2'd3
   } reg_addr_e;

   localparam int REG_DW        = 16;
   localparam int RPTR_RST_BIT  = 15;
   localparam int CTRL_RUN_BIT  = 1;
   localparam int CTRL_IEN_BIT  = 0;
   localparam int STAT_MERR_BIT = 0;
endpackage

// File: rtl/cmd_ring_pfifo.sv
module cmd_ring_pfifo #(
   parameter int W     = 32,
   parameter int DEPTH = 4,
   localparam int PW    = $clog2(DEPTH),
   localparam int CNT_W = $clog2(DEPTH + 1)
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             flush,
   input  logic             push,
   input  logic [W-1:0]     din,
   input  logic             pop,
   output logic             valid,
   output logic [W-1:0]     dout,
   output logic [CNT_W-1:0] count
);
   generate
      if (DEPTH < 2 || (1 << PW) != DEPTH) begin : g_bad_depth
         $error("cmd_ring_pfifo: DEPTH must be a power of two >= 2");
      end
   endgenerate

   localparam logic [PW-1:0]    P_ONE = PW'(1);
   localparam logic [CNT_W-1:0] C_ONE = CNT_W'(1);

   logic [W-1:0]  store [DEPTH];
   logic [PW-1:0] wr_p, rd_p;
   logic          do_pop;

   assign valid  = (count != '0);
   assign dout   = store[rd_p];
   assign do_pop = pop & valid;

   always_ff @(posedge clk) begin
      if (push) store[wr_p] <= din;
   end

   always_ff @(posedge clk) begin
      if (!rst_n || flush) begin
         wr_p  <= '0;
         rd_p  <= '0;
         count <= '0;
      end else begin
         if (push)   wr_p <= wr_p + P_ONE;
         if (do_pop) rd_p <= rd_p + P_ONE;
         case ({push, do_pop})
            2'b10:   count <= count + C_ONE;
            2'b01:   count <= count - C_ONE;
            default: ;
         endcase
      end
   end

   a_r5_no_push_when_full: assert property (@(posedge clk) disable iff (!rst_n)
      push |-> (count < CNT_W'(DEPTH)) || do_pop);
endmodule

// File: rtl/cmd_ring_engine.sv
module cmd_ring_engine #(
   parameter int IDX_W    = 8,
   parameter int PF_DEPTH = 4,
   localparam int CNT_W   = $clog2(PF_DEPTH + 1),
   localparam int ADDR_W  = IDX_W + 2
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              run_en,
   input  logic              ptr_clear,
   input  logic [IDX_W-1:0]  wp,
   input  logic [CNT_W-1:0]  buf_cnt,
   output logic              mem_req_valid,
   input  logic              mem_req_ready,
   output logic [ADDR_W-1:0] mem_req_addr,
   input  logic              mem_rsp_valid,
   input  logic              mem_rsp_err,
   output logic              push,
   output logic              err_evt,
   output logic              busy,
   output logic [IDX_W-1:0]  rp
);
   localparam logic [IDX_W-1:0] I_ONE = IDX_W'(1);
   localparam logic [CNT_W-1:0] C_ONE = CNT_W'(1);

   logic [IDX_W-1:0] ip;        // last index issued
   logic [CNT_W-1:0] out_cnt;   // fetches in flight
   logic             drop;      // discard responses after an error
   logic [CNT_W:0]   occ;
   logic             fire;

   assign occ           = {1'b0, out_cnt} + {1'b0, buf_cnt};
   assign mem_req_valid = run_en & ~drop & ~ptr_clear & (ip != wp)
                        & (occ < (CNT_W+1)'(PF_DEPTH));
   assign mem_req_addr  = {ip + I_ONE, 2'b00};
   assign fire          = mem_req_valid & mem_req_ready;
   assign push          = mem_rsp_valid & ~mem_rsp_err & ~drop;
   assign err_evt       = mem_rsp_valid & mem_rsp_err;
   assign busy          = (out_cnt != '0);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         ip      <= '0;
         rp      <= '0;
         out_cnt <= '0;
         drop    <= 1'b0;
      end else begin
         case ({fire, mem_rsp_valid})
            2'b10:   out_cnt <= out_cnt + C_ONE;
            2'b01:   out_cnt <= out_cnt - C_ONE;
            default: ;
         endcase
         if (ptr_clear) begin
            ip   <= '0;
            rp   <= '0;
            drop <= 1'b0;
         end else begin
            if (fire) ip <= ip + I_ONE;
            if (push) rp <= rp + I_ONE;
            if (err_evt)            drop <= 1'b1;
            else if (out_cnt == '0) drop <= 1'b0;
            // realign the issue point once nothing is in flight
            if ((!run_en || drop) && out_cnt == '0) ip <= rp;
         end
      end
   end

   a_r3_rp_single_step: assert property (@(posedge clk) disable iff (!rst_n)
      (rp != $past(rp)) |-> (rp == $past(rp) + I_ONE) || (rp == '0));
   a_r3_rsp_expected: assert property (@(posedge clk) disable iff (!rst_n)
      mem_rsp_valid |-> busy);
   a_r5_no_overflow: assert property (@(posedge clk) disable iff (!rst_n)
      occ <= (CNT_W+1)'(PF_DEPTH));
   a_r6_fetch_needs_run: assert property (@(posedge clk) disable iff (!rst_n)
      mem_req_valid |-> run_en && !drop);
endmodule

// File: rtl/cmd_ring_regs.sv
module cmd_ring_regs
   import cmd_ring_pkg::*;
#(
   parameter int IDX_W   = 8,
   parameter bit IRQ_REG = 1'b0
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [1:0]        reg_addr,
   input  logic              reg_we,
   input  logic [REG_DW-1:0] reg_wdata,
   output logic [REG_DW-1:0] reg_rdata,
   input  logic [IDX_W-1:0]  rp,
   input  logic              busy,
   input  logic              err_evt,
   output logic [IDX_W-1:0]  wp,
   output logic              run_en,
   output logic              ptr_clear,
   output logic              rst_ack,
   output logic              irq
);
   generate
      if (IDX_W < 2 || IDX_W >= RPTR_RST_BIT) begin : g_bad_idx
         $error("cmd_ring_regs: IDX_W must fit below the reset bit");
      end
   endgenerate

   logic run_req, ien, merr, rst_req, run_rb, stat_clr;

   assign run_en    = run_req;
   assign run_rb    = run_req | busy;
   assign ptr_clear = rst_req & ~run_rb;
   assign stat_clr  = reg_we && reg_addr == RA_STAT && reg_wdata[STAT_MERR_BIT];

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         run_req <= 1'b0;
         ien     <= 1'b0;
         merr    <= 1'b0;
         rst_req <= 1'b0;
         rst_ack <= 1'b0;
         wp      <= '0;
      end else begin
         rst_ack <= ptr_clear;
         if (reg_we) begin
            case (reg_addr)
               RA_RPTR: rst_req <= reg_wdata[RPTR_RST_BIT];
               RA_WPTR: wp      <= reg_wdata[IDX_W-1:0];
               RA_CTRL: begin
                  run_req <= reg_wdata[CTRL_RUN_BIT];
                  ien     <= reg_wdata[CTRL_IEN_BIT];
               end
               default: ;
            endcase
         end
         if (stat_clr) merr <= 1'b0;
         if (err_evt) begin
            merr    <= 1'b1;
            run_req <= 1'b0;
         end
      end
   end

   always_comb begin
      reg_rdata = '0;
      case (reg_addr)
         RA_RPTR: begin
            reg_rdata[IDX_W-1:0]    = rp;
            reg_rdata[RPTR_RST_BIT] = rst_ack;
         end
         RA_WPTR: reg_rdata[IDX_W-1:0] = wp;
         RA_CTRL: begin
            reg_rdata[CTRL_RUN_BIT] = run_rb;
            reg_rdata[CTRL_IEN_BIT] = ien;
         end
         default: reg_rdata[STAT_MERR_BIT] = merr;
      endcase
   end

   generate
      if (IRQ_REG) begin : g_irq_flop
         always_ff @(posedge clk) begin
            if (!rst_n) irq <= 1'b0;
            else        irq <= merr & ien;
         end
      end else begin : g_irq_comb
         assign irq = merr & ien;
      end
   endgenerate

   a_r6_run_reads_busy: assert property (@(posedge clk) disable iff (!rst_n)
      (reg_addr == RA_CTRL && busy) |-> reg_rdata[CTRL_RUN_BIT]);
   a_r9_error_halts: assert property (@(posedge clk) disable iff (!rst_n)
      err_evt |=> !run_req && merr);
   a_r10_merr_w1c: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(merr) |-> $past(stat_clr));
endmodule

// File: rtl/cmd_ring_fetch.sv
module cmd_ring_fetch
   import cmd_ring_pkg::*;
#(
   parameter int IDX_W    = 8,
   parameter int ENTRY_W  = 32,
   parameter int PF_DEPTH = 4,
   parameter bit IRQ_REG  = 1'b0,
   localparam int ADDR_W  = IDX_W + 2,
   localparam int CNT_W   = $clog2(PF_DEPTH + 1)
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic [1:0]         reg_addr,
   input  logic               reg_we,
   input  logic [15:0]        reg_wdata,
   output logic [15:0]        reg_rdata,
   output logic               mem_req_valid,
   input  logic               mem_req_ready,
   output logic [ADDR_W-1:0]  mem_req_addr,
   input  logic               mem_rsp_valid,
   input  logic               mem_rsp_err,
   input  logic [ENTRY_W-1:0] mem_rsp_data,
   output logic               cmd_valid,
   input  logic               cmd_ready,
   output logic [ENTRY_W-1:0] cmd_data,
   output logic               irq
);
   logic [IDX_W-1:0] wp, rp;
   logic             run_en, ptr_clear, rst_ack, busy, err_evt, push;
   logic [CNT_W-1:0] buf_cnt;

   cmd_ring_regs #(.IDX_W(IDX_W), .IRQ_REG(IRQ_REG)) u_regs (
      .clk, .rst_n, .reg_addr, .reg_we, .reg_wdata, .reg_rdata,
      .rp, .busy, .err_evt, .wp, .run_en, .ptr_clear, .rst_ack, .irq
   );

   cmd_ring_engine #(.IDX_W(IDX_W), .PF_DEPTH(PF_DEPTH)) u_eng (
      .clk, .rst_n, .run_en, .ptr_clear, .wp, .buf_cnt,
      .mem_req_valid, .mem_req_ready, .mem_req_addr,
      .mem_rsp_valid, .mem_rsp_err, .push, .err_evt, .busy, .rp
   );

   cmd_ring_pfifo #(.W(ENTRY_W), .DEPTH(PF_DEPTH)) u_buf (
      .clk, .rst_n, .flush(ptr_clear), .push, .din(mem_rsp_data),
      .pop(cmd_ready), .valid(cmd_valid), .dout(cmd_data), .count(buf_cnt)
   );

   a_r7_ack_means_flushed: assert property (@(posedge clk) disable iff (!rst_n)
      rst_ack |-> !cmd_valid && rp == '0);
   a_r7_no_fetch_while_ack: assert property (@(posedge clk) disable iff (!rst_n)
      rst_ack |-> !busy);
endmodule

// File: tb/sim_cmd_ring_fetch.sv
module sim_cmd_ring_fetch;
   localparam int CLK_PERIOD = 10;
   localparam logic [1:0] A_RP = 2'd0, A_WP = 2'd1, A_CT = 2'd2, A_ST = 2'd3;

   logic        clk = 1'b0, rst_n = 1'b0;
   logic [1:0]  reg_addr = '0;
   logic        reg_we = 1'b0;
   logic [15:0] reg_wdata = '0, reg_rdata;
   logic        mem_req_valid, mem_req_ready = 1'b1;
   logic [9:0]  mem_req_addr;
   logic        mem_rsp_valid, mem_rsp_err;
   logic [31:0] mem_rsp_data;
   logic        cmd_valid, cmd_ready = 1'b1, irq;
   logic [31:0] cmd_data;

   int nchk = 0, nfail = 0;
   bit done = 1'b0;
   logic [8:0] err_idx = 9'h100;

   always #(CLK_PERIOD/2) clk = ~clk;

   cmd_ring_fetch u0 (.*);

   // memory model: answers two edges after accepting a request
   logic       p1_v, p2_v;
   logic [9:0] p1_a, p2_a;
   always @(posedge clk) begin
      if (!rst_n) begin
         p1_v <= 1'b0; p2_v <= 1'b0; p1_a <= '0; p2_a <= '0;
      end else begin
         p1_v <= mem_req_valid & mem_req_ready; p1_a <= mem_req_addr;
         p2_v <= p1_v; p2_a <= p1_a;
      end
   end
   assign mem_rsp_valid = p2_v;
   assign mem_rsp_err   = p2_v && ({1'b0, p2_a[9:2]} == err_idx);
   assign mem_rsp_data  = 32'hC0DE_0000 | 32'(p2_a[9:2]);

   // sink: log every delivered command
   logic [31:0] log_q [512];
   int ndel = 0;
   always @(posedge clk) begin
      if (rst_n && cmd_valid && cmd_ready) begin
         log_q[ndel[8:0]] <= cmd_data;
         ndel <= ndel + 1;
      end
   end

   function automatic logic [31:0] ent(input int i);
      return 32'hC0DE_0000 | 32'(i & 255);
   endfunction

   task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
      nchk++;
      if (act !== exp) begin
         nfail++;
         $display("FAIL %s act=%h exp=%h", tag, act, exp);
      end
   endtask

   task automatic wr(input logic [1:0] a, input logic [15:0] d);
      reg_addr = a; reg_wdata = d; reg_we = 1'b1;
      @(negedge clk);
      reg_we = 1'b0;
   endtask

   task automatic rd(input logic [1:0] a, output logic [15:0] v);
      reg_addr = a;
      #1;
      v = reg_rdata;
   endtask

   task automatic idle(input int n);
      repeat (n) @(negedge clk);
   endtask

   // {addr, write data, expected read}
   localparam logic [33:0] VEC [6] = '{
      {2'd1, 16'hFF12, 16'h0012},
      {2'd1, 16'h0005, 16'h0005},
      {2'd2, 16'h00FD, 16'h0001},
      {2'd2, 16'h0000, 16'h0000},
      {2'd0, 16'h00AA, 16'h0000},
      {2'd3, 16'h0001, 16'h0000}
   };

   initial begin
      logic [15:0] v;
      int bad;
      idle(3);
      rst_n = 1'b1;
      // R1 reset state
      for (int a = 0; a < 4; a++) begin
         rd(2'(a), v); chk("R1 register reset value", 32'(v), 32'h0);
      end
      chk("R1 outputs idle", {29'd0, irq, cmd_valid, mem_req_valid}, 32'h0);

      // R2 register map walk
      for (int i = 0; i < 6; i++) begin
         wr(VEC[i][33:32], VEC[i][31:16]);
         rd(VEC[i][33:32], v);
         chk("R2 register vector", 32'(v), 32'(VEC[i][15:0]));
      end

      // R3 basic fetch of entries 1..5
      wr(A_CT, 16'h0002);
      idle(20);
      rd(A_RP, v); chk("R3 read pointer after fetch", 32'(v), 32'd5);
      rd(A_CT, v); chk("R3 run bit while running", 32'(v), 32'h2);
      chk("R3 delivered count", ndel, 5);
      bad = 0;
      for (int i = 0; i < 5; i++) if (log_q[i] !== ent(i + 1)) bad++;
      chk("R3 delivered order and data", bad, 0);

      // R6 stop handshake
      wr(A_CT, 16'h0000);
      rd(A_CT, v); chk("R6 stop when idle", 32'(v), 32'h0);
      wr(A_WP, 16'd10);
      wr(A_CT, 16'h0002);
      wr(A_CT, 16'h0000);
      rd(A_CT, v); chk("R6 run bit held while fetch in flight", 32'(v), 32'h2);
      idle(4);
      rd(A_CT, v); chk("R6 run bit drops after drain", 32'(v), 32'h0);
      rd(A_RP, v); chk("R6 in-flight fetch completed", 32'(v), 32'd6);
      chk("R6 delivered entry 6", log_q[5], ent(6));

      // R5 prefetch bound, R7/R8 pointer reset with flush
      cmd_ready = 1'b0;
      wr(A_WP, 16'd20);
      wr(A_CT, 16'h0002);
      idle(15);
      rd(A_RP, v); chk("R5 stall at buffer depth", 32'(v), 32'd10);
      chk("R5 buffer holds commands", 32'(cmd_valid), 32'd1);
      wr(A_RP, 16'h8000);
      idle(3);
      rd(A_RP, v); chk("R7 reset held off while running", 32'(v), 32'h000A);
      wr(A_CT, 16'h0000);
      idle(1);
      rd(A_RP, v); chk("R7 reset acknowledged, pointer zero", 32'(v), 32'h8000);
      chk("R7 buffer flushed", 32'(cmd_valid), 32'd0);
      wr(A_RP, 16'h0000);
      idle(1);
      rd(A_RP, v); chk("R8 reset bit released", 32'(v), 32'h0000);
      cmd_ready = 1'b1;
      idle(2);
      chk("R7 flushed commands not delivered", ndel, 6);

      // R4 wrap: 1..254 then 255,0,1,2
      wr(A_WP, 16'd254);
      wr(A_CT, 16'h0002);
      idle(400);
      rd(A_RP, v); chk("R4 pointer before wrap", 32'(v), 32'd254);
      wr(A_WP, 16'd2);
      idle(20);
      rd(A_RP, v); chk("R4 pointer after wrap", 32'(v), 32'd2);
      chk("R4 delivered count", ndel, 264);
      bad = 0;
      for (int i = 0; i < 258; i++) if (log_q[6 + i] !== ent(i + 1)) bad++;
      chk("R4 wrapped stream order", bad, 0);
      chk("R4 entry 0 after 255", log_q[261], ent(0));

      // R9 error, R10 clear, R11 interrupt
      wr(A_CT, 16'h0000);
      idle(4);
      err_idx = 9'd4;
      wr(A_WP, 16'd5);
      wr(A_CT, 16'h0003);
      idle(10);
      rd(A_ST, v); chk("R9 error status set", 32'(v), 32'h1);
      chk("R11 irq with enable", 32'(irq), 32'd1);
      rd(A_CT, v); chk("R9 run cleared by error", 32'(v), 32'h1);
      rd(A_RP, v); chk("R9 pointer stops before failed entry", 32'(v), 32'd3);
      chk("R9 in-flight responses dropped", ndel, 265);
      wr(A_CT, 16'h0000);
      chk("R11 irq masked", 32'(irq), 32'd0);
      wr(A_ST, 16'h0000);
      rd(A_ST, v); chk("R10 write 0 keeps status", 32'(v), 32'h1);
      wr(A_CT, 16'h0001);
      chk("R11 irq re-enabled", 32'(irq), 32'd1);
      wr(A_ST, 16'h0001);
      rd(A_ST, v); chk("R10 write 1 clears status", 32'(v), 32'h0);
      chk("R11 irq low after clear", 32'(irq), 32'd0);
      err_idx = 9'h100;
      wr(A_CT, 16'h0002);
      idle(10);
      rd(A_RP, v); chk("R9 restart resumes", 32'(v), 32'd5);
      chk("R9 restart delivers 4", log_q[265], ent(4));
      chk("R9 restart delivers 5", log_q[266], ent(5));

      done = 1'b1;
      $display("TB_RESULT checks=%0d failures=%0d", nchk, nfail);
      $finish;
   end

   initial begin
      repeat (200000) @(posedge clk);
      if (!done) begin
         $display("FAIL watchdog act=running exp=finished");
         $display("TB_RESULT checks=%0d failures=%0d", nchk + 1, nfail + 1);
         $finish;
      end
   end
endmodule